// File: doc/BRIEF.md
# Serial ADC Channel Configuration Receiver

This block is the configuration front end of a four-input converter. A host writes 8-bit setup bytes over a three-wire serial link: an active-low select, a serial clock and a data line. Each byte picks one analog input and sets two things for it: whether it is measured against analog ground or as half of a differential pair, and which input range it uses. The block keeps one setup register per input and drives every input's mode and range on output ports, so the conversion logic can read them directly.

The byte is not framed by a fixed count from the select edge. While the select is low, the receiver discards zero bits until the first one arrives. That one is the leading bit of the byte. The next seven bits complete the byte. The receiver then goes back to hunting for a leading one, so a host may send several bytes in one select frame, with any amount of zero padding between them. The serial pins are brought into the system clock domain through synchronizers, and data is taken on each rising serial-clock edge.

A differential write sets both inputs of the pair. Inputs 0 and 1 form one pair and inputs 2 and 3 form the other. A byte that names a missing input, or that gives a range code the chosen mode does not allow, changes nothing and produces a one-cycle error pulse. Each accepted byte produces a one-cycle update pulse together with the input number it named.

Top module: `adcfg_rx`

## Requirements
- R1: After synchronous reset, every input is in ground-referenced mode (mode bit 0) with range code 0, and neither pulse output is high.
- R2: While select is low, zero bits taken before the first one bit are discarded. Any number of them may precede a byte.
- R3: The receiver takes `sdi` on rising edges of `sclk`, most significant bit first. Bit 7 is the leading one. Bits 6:4 give the input number. Bit 3 is the mode: 0 for ground-referenced, 1 for differential. Bits 2:0 give the range code.
- R4: An accepted ground-referenced byte changes only the named input, storing mode 0 and the range code.
- R5: An accepted differential byte stores mode 1 and the range code on both inputs of the named input's pair (0 with 1, 2 with 3).
- R6: In ground-referenced mode, range codes 0 through 6 are accepted. Code 7 is rejected.
- R7: In differential mode, only range codes 4, 5 and 6 are accepted. Codes 0 to 3 and 7 are rejected.
- R8: A byte whose input number is 4 to 7, or whose range code is rejected, leaves every stored setting unchanged and raises `err_stb` for exactly one cycle.
- R9: If select rises before all 8 bits have arrived, the partial byte is dropped: no setting changes and no pulse is raised.
- R10: After a complete byte, the receiver hunts for a new leading one within the same select frame, so consecutive bytes in one frame are each applied.
- R11: An accepted byte raises `upd_stb` for exactly one cycle, with `upd_ch` equal to the input number in the byte. `upd_stb` and `err_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in |
| mode_o | output | NCH (4) | Per-input mode, 1 = differential |
| range_o | output | NCH*3 (12) | Per-input range code, input i in bits [3i+2:3i] |
| upd_stb | output | 1 | One-cycle pulse on an accepted byte |
| upd_ch | output | 2 | Input number of the last accepted byte |
| err_stb | output | 1 | One-cycle pulse on a rejected byte |

## Verification
The main table sends single bytes with different amounts of leading zero padding. It covers both modes, both pairs, each input number from either half of a pair, the range codes at the edges of each mode's allowed set, and input numbers above 3. A reference model follows every accepted byte, so a write that lands on the wrong input, only half of a pair, or the wrong bit field shows up in the stored settings. Directed cases send two bytes in one frame, cut a frame short after five bits, overwrite one half of a differential pair with a ground-referenced byte, and reset in the middle of operation. These cases separate correct byte framing from a count taken from the select edge.

// File: rtl/adcfg_pkg.sv
package adcfg_pkg;
  localparam int RW     = 3;  // range code width
  localparam int SELW   = 3;  // input-number field width in the byte
  localparam int PAYW   = 7;  // bits following the leading one

  // Accepted range codes: ground-referenced 0..6, differential 4..6
  function automatic logic range_ok(input logic dif, input logic [RW-1:0] code);
    if (dif) return (code >= 3'd4) && (code <= 3'd6);
    else     return (code != 3'd7);
  endfunction
endpackage

// File: rtl/adcfg_sync.sv
module adcfg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/adcfg_shift.sv
module adcfg_shift
  import adcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_act,
  input  logic            sck_rise,
  input  logic            sd,
  output logic            byte_vld,
  output logic [PAYW-1:0] byte_q
);
  localparam int CNTW = $clog2(PAYW);

  logic            hunting;
  logic [CNTW-1:0] cnt;
  logic [PAYW-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      hunting  <= 1'b1;
      cnt      <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!cs_act) begin
        hunting <= 1'b1;
        cnt     <= '0;
      end else if (sck_rise) begin
        if (hunting) begin
          if (sd) begin
            hunting <= 1'b0;
            cnt     <= '0;
          end
        end else begin
          shreg <= {shreg[PAYW-3:0], sd};
          if (cnt == CNTW'(PAYW - 1)) begin
            byte_vld <= 1'b1;
            byte_q   <= {shreg, sd};
            hunting  <= 1'b1;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adcfg_bank.sv
module adcfg_bank
  import adcfg_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [SELW-1:0]   sel,
  input  logic              dif,
  input  logic [RW-1:0]     rng,
  output logic [NCH-1:0]    mode_o,
  output logic [NCH*RW-1:0] range_o,
  output logic              upd_stb,
  output logic [CW-1:0]     upd_ch,
  output logic              err_stb
);
  logic accept;
  assign accept = wr_vld && (int'(sel) < NCH) && range_ok(dif, rng);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CW-1:0] IDX = CW'(i);
    logic hit;
    assign hit = (sel[CW-1:0] == IDX) || (dif && (sel[CW-1:1] == IDX[CW-1:1]));

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_o[i]            <= 1'b0;
        range_o[i*RW +: RW]  <= '0;
      end else if (accept && hit) begin
        mode_o[i]            <= dif;
        range_o[i*RW +: RW]  <= rng;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_stb <= 1'b0;
      err_stb <= 1'b0;
      upd_ch  <= '0;
    end else begin
      upd_stb <= accept;
      err_stb <= wr_vld && !accept;
      if (accept) upd_ch <= sel[CW-1:0];
    end
  end
endmodule

// File: rtl/adcfg_rx.sv
module adcfg_rx
  import adcfg_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [NCH-1:0]    mode_o,
  output logic [NCH*RW-1:0] range_o,
  output logic              upd_stb,
  output logic [CW-1:0]     upd_ch,
  output logic              err_stb
);
  logic            cs_s, sck_s, sd_s, sck_d;
  logic            byte_vld;
  logic [PAYW-1:0] byte_q;

  adcfg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_n, sclk, sdi}),
    .q_o ({cs_s, sck_s, sd_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  adcfg_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (!cs_s),
    .sck_rise (sck_s && !sck_d),
    .sd       (sd_s),
    .byte_vld (byte_vld),
    .byte_q   (byte_q)
  );

  adcfg_bank #(.NCH(NCH)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (byte_vld),
    .sel     (byte_q[6:4]),
    .dif     (byte_q[3]),
    .rng     (byte_q[2:0]),
    .mode_o  (mode_o),
    .range_o (range_o),
    .upd_stb (upd_stb),
    .upd_ch  (upd_ch),
    .err_stb (err_stb)
  );
endmodule

// File: rtl/adcfg_chk.sv
module adcfg_chk
  import adcfg_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    mode_o,
  input logic [NCH*RW-1:0] range_o,
  input logic              upd_stb,
  input logic [CW-1:0]     upd_ch,
  input logic              err_stb
);
  logic [CW-1:0] mate;
  assign mate = upd_ch ^ CW'(1);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_o == '0) && (range_o == '0) && !upd_stb && !err_stb); // R1

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(upd_stb && err_stb)); // R11

  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !upd_stb); // R11

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_stb |=> !err_stb); // R8

  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (rst)
    !upd_stb |-> $stable(mode_o) && $stable(range_o)); // R8

  AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && mode_o[upd_ch]) |->
      mode_o[mate] && (range_o[mate*RW +: RW] == range_o[upd_ch*RW +: RW])); // R5

  AST_STORED_VALID: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> range_ok(mode_o[upd_ch], range_o[upd_ch*RW +: RW])); // R6
endmodule

bind adcfg_rx adcfg_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_o  (mode_o),
  .range_o (range_o),
  .upd_stb (upd_stb),
  .upd_ch  (upd_ch),
  .err_stb (err_stb)
);

// File: tb/tb_adcfg_rx.sv
module tb_adcfg_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;   // clk cycles per serial half period
  localparam int NV         = 11;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [3:0]  mode_o;
  logic [11:0] range_o;
  logic        upd_stb, err_stb;
  logic [1:0]  upd_ch;

  int errors = 0, checks = 0;
  int n_upd = 0, n_err = 0, n_wide = 0;
  logic [1:0] last_ch = '0;
  logic prev_upd = 1'b0, prev_err = 1'b0;
  logic done = 1'b0;
  logic [3:0]  m_mode;
  logic [11:0] m_rng;

  // {lead zeros[3:0], byte[7:0], accepted}
  localparam logic [12:0] VEC [NV] = '{
    {4'd0, 8'h83, 1'b1},   // R4 in0 ground rng3
    {4'd3, 8'h96, 1'b1},   // R6 in1 ground rng6 (top of set)
    {4'd1, 8'hA7, 1'b0},   // R6 in2 ground rng7 rejected
    {4'd5, 8'hBD, 1'b1},   // R5 in3 diff rng5 -> in2+in3
    {4'd2, 8'h8C, 1'b1},   // R7 in0 diff rng4 -> in0+in1
    {4'd0, 8'h89, 1'b0},   // R7 diff rng1 rejected
    {4'd7, 8'hC0, 1'b0},   // R8 input 4 rejected
    {4'd1, 8'hF6, 1'b0},   // R8 input 7 rejected
    {4'd4, 8'h90, 1'b1},   // R4 in1 ground rng0, in0 stays diff
    {4'd0, 8'h9E, 1'b1},   // R5 in1 diff rng6 -> in0+in1
    {4'd2, 8'h8F, 1'b0}    // R7 diff rng7 rejected
  };

  adcfg_rx dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .mode_o(mode_o), .range_o(range_o),
    .upd_stb(upd_stb), .upd_ch(upd_ch), .err_stb(err_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (upd_stb) begin n_upd++; last_ch = upd_ch; end
      if (err_stb) n_err++;
      if ((upd_stb && prev_upd) || (err_stb && prev_err) || (upd_stb && err_stb)) n_wide++;
    end
    prev_upd = upd_stb;
    prev_err = err_stb;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi  = b;
    sclk = 1'b0; wclk(HALF_SCK);
    sclk = 1'b1; wclk(HALF_SCK);
  endtask

  task automatic send_byte(input int lead, input logic [7:0] b);
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic frame_open();
    cs_n = 1'b0; wclk(HALF_SCK);
  endtask

  task automatic frame_close();
    sclk = 1'b0; sdi = 1'b0; wclk(HALF_SCK);
    cs_n = 1'b1; wclk(10);
  endtask

  // Reference model built from R4..R8
  task automatic model_apply(input logic [7:0] b);
    logic [2:0] s, r;
    logic d, ok;
    s = b[6:4]; d = b[3]; r = b[2:0];
    ok = (s < 3'd4) && (d ? (r == 3'd4 || r == 3'd5 || r == 3'd6) : (r != 3'd7));
    if (ok) begin
      if (d) begin
        for (int k = 0; k < 2; k++) begin
          m_mode[{s[1], k[0]}] = 1'b1;
          m_rng[{s[1], k[0]}*3 +: 3] = r;
        end
      end else begin
        m_mode[s[1:0]] = 1'b0;
        m_rng[s[1:0]*3 +: 3] = r;
      end
    end
  endtask

  task automatic chk_cfg(input string req);
    chk(mode_o == m_mode, req, 32'(mode_o), 32'(m_mode));
    chk(range_o == m_rng, req, 32'(range_o), 32'(m_rng));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int u0, e0;
    m_mode = '0; m_rng = '0;
    wclk(5); rst = 1'b0; wclk(5);
    // R1 reset state
    chk_cfg("R1");
    chk(n_upd == 0 && n_err == 0, "R1 no pulses", 32'(n_upd + n_err), 0);

    // Table: one byte per frame, varied zero padding (R2, R3)
    for (int v = 0; v < NV; v++) begin
      u0 = n_upd; e0 = n_err;
      frame_open();
      send_byte(int'(VEC[v][12:9]), VEC[v][8:1]);
      frame_close();
      model_apply(VEC[v][8:1]);
      chk_cfg("R3 R4 R5 config");
      if (VEC[v][0]) begin
        chk(n_upd == u0 + 1 && n_err == e0, "R11 update pulse", 32'(n_upd - u0), 1);
        chk(last_ch == VEC[v][6:5], "R11 upd_ch", 32'(last_ch), 32'(VEC[v][6:5]));
      end else begin
        chk(n_err == e0 + 1 && n_upd == u0, "R8 error pulse", 32'(n_err - e0), 1);
      end
    end

    // R10: two bytes in one frame with padding between
    u0 = n_upd;
    frame_open();
    send_byte(2, 8'hA5);          // in2 ground rng5
    send_byte(3, 8'h84);          // in0 ground rng4
    frame_close();
    model_apply(8'hA5); model_apply(8'h84);
    chk_cfg("R10 two bytes");
    chk(n_upd == u0 + 2, "R10 both applied", 32'(n_upd - u0), 2);
    chk(last_ch == 2'd0, "R10 last channel", 32'(last_ch), 0);

    // R9: frame cut after five bits
    u0 = n_upd; e0 = n_err;
    frame_open();
    for (int i = 7; i >= 3; i--) send_bit(8'hB2 >> i);
    frame_close();
    chk_cfg("R9 partial dropped");
    chk(n_upd == u0 && n_err == e0, "R9 no pulse", 32'(n_upd - u0 + n_err - e0), 0);
    // next frame must frame afresh; leftover bits must not combine
    frame_open();
    send_byte(0, 8'h92);          // in1 ground rng2
    frame_close();
    model_apply(8'h92);
    chk_cfg("R9 R2 reframe");

    chk(n_wide == 0, "R11 pulse width", 32'(n_wide), 0);

    // R1: reset mid-operation
    rst = 1'b1; wclk(3); rst = 1'b0; wclk(3);
    m_mode = '0; m_rng = '0;
    chk_cfg("R1 re-reset");

    finish_run();
  end
endmodule